// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line. An external enable pulse `tick16_i` arrives sixteen times per bit period. Each frame is assembled in an internal shift register. When the frame completes, the block decides whether the shift register is copied into the output data register. It also updates four status indications: received data available, overrun, framing error and parity error. The receiver can be set for an optional even or odd parity bit and for one or two stop bits.

The received byte leaves through a valid/ready interface. `rx_valid_o` means a cleanly received byte is waiting in `rx_data_o`. A cycle with both `rx_valid_o` and `rx_ready_i` high consumes it. Back-pressure is not buffered. If the host keeps `rx_ready_i` low while another frame completes, that frame is discarded and the overrun flag is raised. The held byte and its valid indication stay untouched.

A frame that carries a framing or parity error still lands in `rx_data_o`, but `rx_valid_o` is not raised for it. The three error flags are sticky, and each one is cleared only by its own host strobe. A held-low line (break) makes the receiver frame a run of all-zero characters, so the framing flag keeps coming back after each clear.

Top module: `uart_rx_core`

## Requirements
- R1: A frame has one low start bit, then 8 data bits with the least significant bit first, then a parity bit only when `par_en_i` is 1, then one stop bit (two when `two_stop_i` is 1). Each bit lasts 16 `tick16_i` pulses. A frame with no error loads its byte into `rx_data_o` and raises `rx_valid_o`.
- R2: While `rx_valid_o` is 1 and `rx_ready_i` is 0, both `rx_valid_o` and `rx_data_o` hold their values. A cycle with both signals at 1 drops `rx_valid_o` on the next cycle, unless a new frame completes in that same cycle.
- R3: A stop bit sampled at 0 sets `frm_flag_o`. With two stop bits, either stop bit counts. The byte is still loaded into `rx_data_o`, and `rx_valid_o` stays 0.
- R4: With `par_odd_i` at 0, the data bits plus the parity bit must hold an even number of ones. With `par_odd_i` at 1, they must hold an odd number. A mismatch sets `par_flag_o`, the byte is still loaded, and `rx_valid_o` stays 0.
- R5: A frame with both a framing error and a parity error sets both flags, loads the byte, and leaves `rx_valid_o` at 0.
- R6: A frame that completes while `rx_valid_o` is 1 and `rx_ready_i` is 0 sets `ovr_flag_o`. It is not loaded, and `rx_valid_o` stays 1. Its framing and parity errors are still recorded in their own flags.
- R7: Each error flag stays set until its own clear strobe (`clr_ovr_i`, `clr_frm_i`, `clr_par_i`) is high. When a set and that flag's clear fall in the same cycle, the flag ends up set.
- R8: A line held at 0 produces frames of 0x00 that set `frm_flag_o`, and in odd parity also `par_flag_o`. After the host clears `frm_flag_o` during the break, it is set again.
- R9: While `rx_en_i` is 0, no frame is received. The data register, `rx_valid_o` and all error flags keep their values.
- R10: A low pulse on the line that is shorter than half a bit is not taken as a start bit and changes no output.
- R11: After reset, `rx_data_o` is 0 and `rx_valid_o` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Enable pulse at sixteen times the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | A parity bit follows the data bits |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop_i | input | 1 | Frame ends with two stop bits |
| rx_data_o | output | DATA_W | Most recently loaded byte |
| rx_valid_o | output | 1 | A cleanly received byte is waiting |
| rx_ready_i | input | 1 | Host accepts the waiting byte |
| clr_ovr_i | input | 1 | Clear strobe for the overrun flag |
| clr_frm_i | input | 1 | Clear strobe for the framing flag |
| clr_par_i | input | 1 | Clear strobe for the parity flag |
| ovr_flag_o | output | 1 | Overrun flag |
| frm_flag_o | output | 1 | Framing error flag |
| par_flag_o | output | 1 | Parity error flag |

## Verification
Two events can land in the same clock edge: the host's clear strobe for the framing flag and the completion of a frame whose stop bit is low.

The bench provokes this by raising `clr_frm_i` at the start of a bad stop bit and holding it until the flag is seen high. The flag must end up set. If the clear won, the flag would stay low through the whole bit and the scoreboard entry for that frame would report it.

A second collision is tested with a frame that completes while an earlier byte is still unread. In that case the data register must keep the old byte while the overrun, framing and parity flags update together.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int FLAG_OVR = 0;
  localparam int FLAG_FRM = 1;
  localparam int FLAG_PAR = 2;
  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= 1'b1;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frm_err_o,
  output logic              par_err_o
);

  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_acc_q;
  logic              ferr_q;
  logic              perr_q;
  logic              stop2_q;
  logic              done_q;

  logic              at_mid;
  logic [CNT_W-1:0]  cnt_step;
  logic              ferr_next;

  // Mid-bit point of a full bit period, counted from the previous sample.
  assign at_mid    = (cnt_q == FULL_LAST);
  assign cnt_step  = at_mid ? '0 : cnt_q + 1'b1;
  assign ferr_next = ferr_q | ~rx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_acc_q <= 1'b0;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
      stop2_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == HALF_LAST) begin
              cnt_q <= '0;
              if (!rx_i) begin
                state_q   <= RX_DATA;
                idx_q     <= '0;
                par_acc_q <= par_odd_i;
                ferr_q    <= 1'b0;
                perr_q    <= 1'b0;
                stop2_q   <= 1'b0;
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            cnt_q <= cnt_step;
            if (at_mid) begin
              shift_q   <= {rx_i, shift_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ rx_i;
              if (idx_q == LAST_IDX) begin
                state_q <= par_en_i ? RX_PAR : RX_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          RX_PAR: begin
            cnt_q <= cnt_step;
            if (at_mid) begin
              perr_q  <= par_acc_q ^ rx_i;
              state_q <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt_q <= cnt_step;
            if (at_mid) begin
              ferr_q <= ferr_next;
              if (two_stop_i && !stop2_q) begin
                stop2_q <= 1'b1;
              end else begin
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = shift_q;
  assign frm_err_o = ferr_q;
  assign par_err_o = perr_q;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              ready_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o
);

  logic [DATA_W-1:0]    data_q;
  logic                 valid_q;
  logic                 ovr_hit;
  logic                 consume;
  logic                 clean;
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic [NUM_FLAGS-1:0] flag_v;

  // The held byte is still pending unless the host takes it this cycle.
  assign consume = valid_q & ready_i;
  assign ovr_hit = done_i & valid_q & ~ready_i;
  assign clean   = ~(frm_err_i | par_err_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (done_i && !ovr_hit) begin
      data_q  <= data_i;
      valid_q <= clean;
    end else if (consume) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[FLAG_OVR] = ovr_hit;
    set_v[FLAG_FRM] = done_i & frm_err_i;
    set_v[FLAG_PAR] = done_i & par_err_i;
    clr_v[FLAG_OVR] = clr_ovr_i;
    clr_v[FLAG_FRM] = clr_frm_i;
    clr_v[FLAG_PAR] = clr_par_i;
  end

  generate
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= set_v[g] | (bit_q & ~clr_v[g]);
      end
      assign flag_v[g] = bit_q;
    end
  endgenerate

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ovr_o   = flag_v[FLAG_OVR];
  assign frm_o   = flag_v[FLAG_FRM];
  assign par_o   = flag_v[FLAG_PAR];

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic              ovr_flag_o,
  output logic              frm_flag_o,
  output logic              par_flag_o
);

  logic              rx_sync;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_ferr;
  logic              frame_perr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (rx_en_i),
    .tick_i     (tick16_i),
    .rx_i       (rx_sync),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .done_o     (frame_done),
    .data_o     (frame_data),
    .frm_err_o  (frame_ferr),
    .par_err_o  (frame_perr)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (frame_done),
    .data_i    (frame_data),
    .frm_err_i (frame_ferr),
    .par_err_i (frame_perr),
    .ready_i   (rx_ready_i),
    .clr_ovr_i (clr_ovr_i),
    .clr_frm_i (clr_frm_i),
    .clr_par_i (clr_par_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .ovr_o     (ovr_flag_o),
    .frm_o     (frm_flag_o),
    .par_o     (par_flag_o)
  );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic              rx_ready_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              ovr_flag_o,
  input logic              frm_flag_o,
  input logic              par_flag_o,
  input logic              clr_ovr_i,
  input logic              clr_frm_i,
  input logic              clr_par_i,
  input logic              frame_done
);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> $stable(rx_data_o));

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && rx_ready_i && !frame_done |=> !rx_valid_o);

  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag_o) |-> $past(rx_valid_o) && !$past(rx_ready_i));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag_o && !clr_ovr_i |=> ovr_flag_o);

  // R7
  frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_flag_o && !clr_frm_i |=> frm_flag_o);

  // R7
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_flag_o && !clr_par_i |=> par_flag_o);

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !frame_done);

endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en_i    (rx_en_i),
  .rx_ready_i (rx_ready_i),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o),
  .ovr_flag_o (ovr_flag_o),
  .frm_flag_o (frm_flag_o),
  .par_flag_o (par_flag_o),
  .clr_ovr_i  (clr_ovr_i),
  .clr_frm_i  (clr_frm_i),
  .clr_par_i  (clr_par_i),
  .frame_done (frame_done)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OVS        = 16;
  localparam int BITC       = OVS * TICK_DIV;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       rx_ready = 1'b0;
  logic       clr_ovr = 1'b0;
  logic       clr_frm = 1'b0;
  logic       clr_par = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       ovr_flag_o;
  logic       frm_flag_o;
  logic       par_flag_o;

  typedef struct {
    logic [7:0] data;
    logic       valid;
    logic       ovr;
    logic       frm;
    logic       par;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event sent_ev;
  int   checks = 0;
  int   errors = 0;

  logic [7:0] m_data = 8'h00;
  logic       m_valid = 1'b0;
  logic       m_ovr = 1'b0;
  logic       m_frm = 1'b0;
  logic       m_par = 1'b0;

  uart_rx_core #(.DATA_W(8), .OVS(OVS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .tick16_i   (tick),
    .rx_en_i    (rx_en),
    .par_en_i   (par_en),
    .par_odd_i  (par_odd),
    .two_stop_i (two_stop),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready),
    .clr_ovr_i  (clr_ovr),
    .clr_frm_i  (clr_frm),
    .clr_par_i  (clr_par),
    .ovr_flag_o (ovr_flag_o),
    .frm_flag_o (frm_flag_o),
    .par_flag_o (par_flag_o)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_model(input string req);
    chk_eq(req, "data", rx_data_o, m_data);
    chk_eq(req, "valid", rx_valid_o, m_valid);
    chk_eq(req, "ovr", ovr_flag_o, m_ovr);
    chk_eq(req, "frm", frm_flag_o, m_frm);
    chk_eq(req, "par", par_flag_o, m_par);
  endtask

  task automatic drive_bit(input logic v);
    rx = v;
    repeat (BITC) @(negedge clk);
  endtask

  // Driver: sends one frame, updates the bench model, queues the expectation.
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic [1:0] bad_stop,
                            input bit clr_in_stop, input bit model_on, input string req);
    logic pbit;
    bit   fe;
    bit   pe;
    exp_t e;
    pbit = (^d) ^ par_odd;
    if (bad_par) pbit = ~pbit;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit(pbit);
    rx = ~bad_stop[0];
    if (clr_in_stop) clr_frm = 1'b1;
    for (int i = 0; i < BITC; i++) begin
      @(negedge clk);
      if (clr_in_stop && frm_flag_o) clr_frm = 1'b0;
    end
    clr_frm = 1'b0;
    if (two_stop) drive_bit(~bad_stop[1]);
    rx = 1'b1;
    fe = bad_stop[0] | (two_stop & bad_stop[1]);
    pe = bad_par & par_en;
    if (model_on) begin
      if (m_valid) begin
        m_ovr = 1'b1;
      end else begin
        m_data  = d;
        m_valid = ~(fe | pe);
      end
      m_frm = m_frm | fe;
      m_par = m_par | pe;
    end
    e.data  = m_data;
    e.valid = m_valid;
    e.ovr   = m_ovr;
    e.frm   = m_frm;
    e.par   = m_par;
    e.req   = req;
    exp_q.push_back(e);
    ->sent_ev;
    repeat (BITC) @(negedge clk);
  endtask

  // Monitor: compares the outputs against the queued expectation.
  initial forever begin
    exp_t e;
    @(sent_ev);
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk_eq(e.req, "data", rx_data_o, e.data);
      chk_eq(e.req, "valid", rx_valid_o, e.valid);
      chk_eq(e.req, "ovr", ovr_flag_o, e.ovr);
      chk_eq(e.req, "frm", frm_flag_o, e.frm);
      chk_eq(e.req, "par", par_flag_o, e.par);
    end
  end

  task automatic take(input string req);
    chk_eq(req, "valid before read", rx_valid_o, 1);
    chk_eq(req, "data at read", rx_data_o, m_data);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    m_valid = 1'b0;
    chk_eq(req, "valid after read", rx_valid_o, 0);
  endtask

  task automatic clear(input bit o, input bit f, input bit p, input string req);
    clr_ovr = o;
    clr_frm = f;
    clr_par = p;
    @(negedge clk);
    clr_ovr = 1'b0;
    clr_frm = 1'b0;
    clr_par = 1'b0;
    if (o) m_ovr = 1'b0;
    if (f) m_frm = 1'b0;
    if (p) m_par = 1'b0;
    chk_eq(req, "ovr after clear", ovr_flag_o, m_ovr);
    chk_eq(req, "frm after clear", frm_flag_o, m_frm);
    chk_eq(req, "par after clear", par_flag_o, m_par);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check_model("R11");
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (BITC) @(negedge clk);

    // R1 clean frame, R2 hold and handshake
    send_frame(8'hA5, 0, 2'b00, 0, 1, "R1");
    repeat (40) @(negedge clk);
    chk_eq("R2", "valid held", rx_valid_o, 1);
    chk_eq("R2", "data held", rx_data_o, 8'hA5);
    take("R2");

    // R6 overrun on a clean frame, R7 sticky after read
    send_frame(8'h3C, 0, 2'b00, 0, 1, "R1");
    send_frame(8'h5A, 0, 2'b00, 0, 1, "R6");
    take("R6");
    chk_eq("R7", "ovr sticky after read", ovr_flag_o, 1);
    clear(1, 0, 0, "R7");

    // R4 even parity error, then good even frame
    par_en = 1'b1;
    par_odd = 1'b0;
    send_frame(8'h37, 1, 2'b00, 0, 1, "R4");
    clear(0, 0, 1, "R4");
    send_frame(8'hC3, 0, 2'b00, 0, 1, "R1");
    take("R1");

    // R4 odd parity good and bad
    par_odd = 1'b1;
    send_frame(8'h81, 0, 2'b00, 0, 1, "R1");
    take("R1");
    send_frame(8'h80, 1, 2'b00, 0, 1, "R4");
    clear(0, 0, 1, "R4");

    // R3 framing error with no parity
    par_en = 1'b0;
    send_frame(8'h0F, 0, 2'b01, 0, 1, "R3");
    clear(0, 1, 0, "R3");

    // R5 framing and parity together
    par_en = 1'b1;
    par_odd = 1'b0;
    send_frame(8'h66, 1, 2'b01, 0, 1, "R5");
    clear(0, 1, 1, "R5");

    // R6 overrun together with framing and parity errors
    send_frame(8'h11, 0, 2'b00, 0, 1, "R1");
    send_frame(8'h22, 1, 2'b01, 0, 1, "R6");
    take("R6");
    clear(1, 1, 1, "R6");

    // R3 second stop bit low
    par_en = 1'b0;
    two_stop = 1'b1;
    send_frame(8'h99, 0, 2'b10, 0, 1, "R3");
    clear(0, 1, 0, "R3");
    send_frame(8'h5C, 0, 2'b00, 0, 1, "R1");
    take("R1");

    // R7 set beats clear in the same cycle
    two_stop = 1'b0;
    send_frame(8'h44, 0, 2'b01, 1, 1, "R7");

    // R9 enable low keeps state and ignores the line
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R9", "frm kept with enable low", frm_flag_o, 1);
    send_frame(8'h77, 0, 2'b00, 0, 0, "R9");
    rx_en = 1'b1;
    clear(0, 1, 0, "R9");

    // R10 short low pulse
    rx = 1'b0;
    repeat (OVS / 4 * TICK_DIV) @(negedge clk);
    rx = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    check_model("R10");

    // R8 break with odd parity
    par_en = 1'b1;
    par_odd = 1'b1;
    rx = 1'b0;
    repeat (BITC * 25) @(negedge clk);
    chk_eq("R8", "frm in break", frm_flag_o, 1);
    chk_eq("R8", "par in break", par_flag_o, 1);
    chk_eq("R8", "data in break", rx_data_o, 8'h00);
    chk_eq("R8", "valid in break", rx_valid_o, 0);
    for (int k = 0; k < 3; k++) begin
      clr_frm = 1'b1;
      @(negedge clk);
      clr_frm = 1'b0;
      if (!frm_flag_o) break;
    end
    chk_eq("R8", "frm cleared in break", frm_flag_o, 0);
    repeat (BITC * 25) @(negedge clk);
    chk_eq("R8", "frm set again in break", frm_flag_o, 1);

    repeat (4) @(negedge clk);
    report();
  end

endmodule